// File: doc/BRIEF.md
# Instruction Cache Set Parity Scanner

This block walks every way of one instruction cache set and reports whether any stored parity disagrees with the bits it protects. A single-cycle start pulse supplies a set index and a flag that selects a scan of the tags only or of the tags plus the data. The scanner then drives a read port into the tag and data arrays. That port returns its response exactly one cycle after each request. The scanner checks each response while the next request is already in flight.

For each way, the tag read is checked for its two split tag parities and for the mirrored copy of the valid bit. When data checking is on, four data beats follow the tag read. Each beat is checked for predecode parity and for the per-byte parity of two instructions. When the scan finishes, a one-cycle done pulse marks a result word that carries a tag-parity flag and a data-parity flag, together with the number of the first way that failed. The result stays unchanged until the next accepted start.

Top module: `icache_parity_scan`

## Requirements
- R1: Ways are visited 0,1,2,3 in order. Each way starts with a tag read (rd_data=0) at address (way<<13)|set_idx. When data checking is on, four data reads (rd_data=1) follow it at address (way<<13)|set_idx|(beat<<3), with beat 0..3 in increasing order.
- R2: With data_chk=0 a scan issues exactly four tag reads and no data read.
- R3: For a way whose valid bit (rd_hi bit 29 of the tag read) is 1, tag-low bit 10 must equal the XOR of tag-low bits 23..0 with bits 10 and 11 left out. A mismatch sets the tag-parity flag.
- R4: For a valid way, tag-low bit 11 must equal the XOR of tag-low bits 63..24. A mismatch sets the tag-parity flag.
- R5: For every way, valid or not, tag-high bit 27 must equal tag-high bit 29. A difference sets the tag-parity flag.
- R6: For a way whose valid bit is 0, mismatches in the two tag-low parity bits are ignored.
- R7: For a data beat, rd_hi bit 16 must equal the XOR of rd_hi bits 15..8 (predecode byte). A mismatch sets the data-parity flag.
- R8: For a data beat, rd_hi bits 7..4 hold the even byte parities of instruction A (rd_lo[63:32]) and bits 3..0 those of instruction B (rd_lo[31:0]). Bit 7 (or 3) covers the most significant instruction byte and bit 4 (or 0) the least. Any mismatch sets the data-parity flag.
- R9: The result word has the tag-parity flag in bit 29 and the data-parity flag in bit 28, and all other bits are 0. With data_chk=0, data content has no effect on the result.
- R10: fail_way reports the lowest-numbered way with any parity failure in the scan. A later failure does not overwrite it, and it is 0 when nothing failed.
- R11: A start pulse that arrives while a scan is running is ignored. It changes neither the reads nor the result.
- R12: The result and fail_way clear to 0 in the cycle after a start is accepted. After done they hold until the next accepted start.
- R13: done is a one-cycle pulse that is high N+1 clock edges after the edge that samples start, where N is the number of reads in the scan (20 with data checking, 4 without). After reset, done, rd_en, result and fail_way are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| set_idx | input | 13 | Set index ORed into every array address |
| data_chk | input | 1 | Also read and check the four data beats per way |
| rd_en | output | 1 | Array read request |
| rd_data | output | 1 | 1 selects the data array, 0 the tag array |
| rd_addr | output | 15 | Array address: way, set index and beat |
| rd_hi | input | 32 | Tag-high or data-high word, one cycle after rd_en |
| rd_lo | input | 64 | Tag-low doubleword, or instruction A (upper) and B (lower) |
| done | output | 1 | One-cycle scan-complete pulse |
| result | output | 32 | Bit 29 tag-parity flag, bit 28 data-parity flag |
| fail_way | output | 2 | First way that failed in the scan |

## Verification
The hardest situations to reach are the ones where two things interact. One is several failures in one scan, where only the earliest way may be reported. Another is a second start that lands mid-scan after a flag is already set and must not clear it. A third is a way marked invalid whose tag-low parities are wrong on purpose. The bench keeps its own model of the arrays and computes correct parity bits for every tag and beat. Each case then flips chosen bits: single bits, or pairs of bits that only a correct byte-to-parity-bit mapping cancels. The bench also pulses start again a few cycles into a running scan, in which way 0 already carries an error.

// File: rtl/ipscan_pkg.sv
package ipscan_pkg;

  localparam int TAG_FLAG_BIT   = 29;
  localparam int DATA_FLAG_BIT  = 28;
  localparam int RESULT_W       = 32;
  localparam int HI_W           = 32;
  localparam int LO_W           = 64;
  localparam int INST_W         = 32;
  localparam int VALID_BIT      = 29;
  localparam int MIRROR_BIT     = 27;
  localparam int LOW_PAR_BIT    = 10;
  localparam int HIGH_PAR_BIT   = 11;
  localparam int PRE_PAR_BIT    = 16;
  localparam int LOW_SPAN_TOP   = 23;
  localparam int HIGH_SPAN_BOT  = 24;
  localparam logic [LOW_SPAN_TOP:0] LOW_SPAN_MASK = 24'hFFF3FF;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ISSUE = 2'd1,
    SC_DRAIN = 2'd2
  } scan_state_e;

  // Parity of the lower tag span with both stored parity bits removed.
  function automatic logic low_span_parity(input logic [LO_W-1:0] lo);
    return ^(lo[LOW_SPAN_TOP:0] & LOW_SPAN_MASK);
  endfunction

  // Parity of the upper tag span.
  function automatic logic high_span_parity(input logic [LO_W-1:0] lo);
    return ^lo[LO_W-1:HIGH_SPAN_BOT];
  endfunction

  // Even parity per byte; byte k lands in bit k, so the top byte is the top bit.
  function automatic logic [3:0] byte_parities(input logic [INST_W-1:0] w);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ^w[8*k +: 8];
    return p;
  endfunction

  function automatic logic predecode_parity(input logic [7:0] pd);
    return ^pd;
  endfunction

endpackage

// File: rtl/ipscan_tag_chk.sv
module ipscan_tag_chk
  import ipscan_pkg::*;
(
  input  logic            vld,
  input  logic            vld_mirror,
  input  logic [LO_W-1:0] tag_lo,
  output logic            tag_bad
);

  logic low_bad;
  logic high_bad;
  logic mirror_bad;

  always_comb begin
    low_bad    = vld & (tag_lo[LOW_PAR_BIT]  != low_span_parity(tag_lo));
    high_bad   = vld & (tag_lo[HIGH_PAR_BIT] != high_span_parity(tag_lo));
    mirror_bad = vld != vld_mirror;
    tag_bad    = low_bad | high_bad | mirror_bad;
  end

endmodule

// File: rtl/ipscan_data_chk.sv
module ipscan_data_chk
  import ipscan_pkg::*;
(
  input  logic [PRE_PAR_BIT:0] beat_hi,
  input  logic [INST_W-1:0]    inst_a,
  input  logic [INST_W-1:0]    inst_b,
  output logic                 data_bad
);

  logic pre_bad;
  logic a_bad;
  logic b_bad;

  always_comb begin
    pre_bad  = beat_hi[PRE_PAR_BIT] != predecode_parity(beat_hi[15:8]);
    a_bad    = beat_hi[7:4] != byte_parities(inst_a);
    b_bad    = beat_hi[3:0] != byte_parities(inst_b);
    data_bad = pre_bad | a_bad | b_bad;
  end

endmodule

// File: rtl/ipscan_walker.sv
module ipscan_walker
  import ipscan_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int NUM_BEATS  = 4,
  parameter int WAY_SHIFT  = 13,
  parameter int BEAT_SHIFT = 3,
  localparam int IDX_W     = WAY_SHIFT,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int ADDR_W    = WAY_SHIFT + WAY_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              data_chk,
  output logic              rd_en,
  output logic              rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              start_acc,
  output logic              busy,
  output logic              rsp_vld,
  output logic              rsp_is_data,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              done
);

  localparam int STEP_W = $clog2(NUM_BEATS + 1);
  localparam int BEAT_W = $clog2(NUM_BEATS);

  scan_state_e       state_q;
  logic [WAY_W-1:0]  way_q;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0]  idx_q;
  logic              dchk_q;
  logic              rsp_last_q;

  logic [STEP_W-1:0] last_step;
  logic              step_end;
  logic              way_end;
  logic              issue;
  logic              final_issue;
  logic              is_data_step;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] beat_part;

  always_comb begin
    last_step    = dchk_q ? STEP_W'(NUM_BEATS) : '0;
    step_end     = step_q == last_step;
    way_end      = way_q == WAY_W'(NUM_WAYS - 1);
    issue        = state_q == SC_ISSUE;
    final_issue  = issue & step_end & way_end;
    is_data_step = step_q != '0;
    beat         = BEAT_W'(step_q - STEP_W'(1));
    beat_part    = is_data_step ? (ADDR_W'(beat) << BEAT_SHIFT) : '0;
    start_acc    = start & (state_q == SC_IDLE);
    busy         = state_q != SC_IDLE;
    rd_en        = issue;
    rd_data      = issue & is_data_step;
    rd_addr      = (ADDR_W'(way_q) << WAY_SHIFT) | ADDR_W'(idx_q) | beat_part;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      way_q   <= '0;
      step_q  <= '0;
      idx_q   <= '0;
      dchk_q  <= 1'b0;
    end else begin
      case (state_q)
        SC_IDLE: begin
          if (start) begin
            idx_q   <= set_idx;
            dchk_q  <= data_chk;
            way_q   <= '0;
            step_q  <= '0;
            state_q <= SC_ISSUE;
          end
        end
        SC_ISSUE: begin
          if (step_end) begin
            step_q <= '0;
            if (way_end) state_q <= SC_DRAIN;
            else         way_q   <= way_q + 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        SC_DRAIN: state_q <= SC_IDLE;
        default:  state_q <= SC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld     <= 1'b0;
      rsp_is_data <= 1'b0;
      rsp_way     <= '0;
      rsp_last_q  <= 1'b0;
      done        <= 1'b0;
    end else begin
      rsp_vld     <= issue;
      rsp_is_data <= issue & is_data_step;
      rsp_way     <= way_q;
      rsp_last_q  <= final_issue;
      done        <= rsp_vld & rsp_last_q;
    end
  end

  AST_TAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !$past(rd_en)) |-> (!rd_data && rd_addr[ADDR_W-1 -: WAY_W] == '0)); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(idx_q) && $stable(dchk_q))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rsp_vld) && !busy)); // R13

endmodule

// File: rtl/ipscan_collect.sv
module ipscan_collect
  import ipscan_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_acc,
  input  logic                busy,
  input  logic                rsp_vld,
  input  logic                rsp_is_data,
  input  logic [WAY_W-1:0]    rsp_way,
  input  logic                rsp_vld_bit,
  input  logic                rsp_mirror_bit,
  input  logic                tag_bad,
  input  logic                data_bad,
  output logic [RESULT_W-1:0] result,
  output logic [WAY_W-1:0]    fail_way
);

  logic tag_f;
  logic data_f;
  logic found_q;
  logic hit_tag;
  logic hit_data;
  logic hit_any;

  always_comb begin
    hit_tag  = rsp_vld & ~rsp_is_data & tag_bad;
    hit_data = rsp_vld &  rsp_is_data & data_bad;
    hit_any  = hit_tag | hit_data;
    result   = '0;
    result[TAG_FLAG_BIT]  = tag_f;
    result[DATA_FLAG_BIT] = data_f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_f    <= 1'b0;
      data_f   <= 1'b0;
      found_q  <= 1'b0;
      fail_way <= '0;
    end else if (start_acc) begin
      tag_f    <= 1'b0;
      data_f   <= 1'b0;
      found_q  <= 1'b0;
      fail_way <= '0;
    end else begin
      if (hit_tag)  tag_f  <= 1'b1;
      if (hit_data) data_f <= 1'b1;
      if (hit_any && !found_q) begin
        found_q  <= 1'b1;
        fail_way <= rsp_way;
      end
    end
  end

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (result == '0 && fail_way == '0)); // R12
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> ($stable(result) && $stable(fail_way))); // R12
  AST_FIRST_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && !start_acc) |=> $stable(fail_way)); // R10
  AST_DATA_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_f) |-> $past(rsp_vld && rsp_is_data)); // R9
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_is_data && !rsp_vld_bit && !rsp_mirror_bit && !start_acc && !tag_f)
      |=> !tag_f); // R6

endmodule

// File: rtl/icache_parity_scan.sv
module icache_parity_scan
  import ipscan_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int NUM_BEATS  = 4,
  parameter int WAY_SHIFT  = 13,
  parameter int BEAT_SHIFT = 3,
  localparam int IDX_W     = WAY_SHIFT,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int ADDR_W    = WAY_SHIFT + WAY_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                data_chk,
  output logic                rd_en,
  output logic                rd_data,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [HI_W-1:0]     rd_hi,
  input  logic [LO_W-1:0]     rd_lo,
  output logic                done,
  output logic [RESULT_W-1:0] result,
  output logic [WAY_W-1:0]    fail_way
);

  logic             start_acc;
  logic             busy;
  logic             rsp_vld;
  logic             rsp_is_data;
  logic [WAY_W-1:0] rsp_way;
  logic             tag_bad;
  logic             data_bad;
  logic             unused_hi;

  assign unused_hi = ^{rd_hi[HI_W-1:VALID_BIT+1], rd_hi[VALID_BIT-1:MIRROR_BIT+1],
                       rd_hi[MIRROR_BIT-1:PRE_PAR_BIT+1]};

  ipscan_walker #(
    .NUM_WAYS   (NUM_WAYS),
    .NUM_BEATS  (NUM_BEATS),
    .WAY_SHIFT  (WAY_SHIFT),
    .BEAT_SHIFT (BEAT_SHIFT)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .set_idx     (set_idx),
    .data_chk    (data_chk),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_addr     (rd_addr),
    .start_acc   (start_acc),
    .busy        (busy),
    .rsp_vld     (rsp_vld),
    .rsp_is_data (rsp_is_data),
    .rsp_way     (rsp_way),
    .done        (done)
  );

  ipscan_tag_chk u_tag_chk (
    .vld        (rd_hi[VALID_BIT]),
    .vld_mirror (rd_hi[MIRROR_BIT]),
    .tag_lo     (rd_lo),
    .tag_bad    (tag_bad)
  );

  ipscan_data_chk u_data_chk (
    .beat_hi  (rd_hi[PRE_PAR_BIT:0]),
    .inst_a   (rd_lo[LO_W-1:INST_W]),
    .inst_b   (rd_lo[INST_W-1:0]),
    .data_bad (data_bad)
  );

  ipscan_collect #(
    .NUM_WAYS (NUM_WAYS)
  ) u_collect (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_acc      (start_acc),
    .busy           (busy),
    .rsp_vld        (rsp_vld),
    .rsp_is_data    (rsp_is_data),
    .rsp_way        (rsp_way),
    .rsp_vld_bit    (rd_hi[VALID_BIT]),
    .rsp_mirror_bit (rd_hi[MIRROR_BIT]),
    .tag_bad        (tag_bad),
    .data_bad       (data_bad),
    .result         (result),
    .fail_way       (fail_way)
  );

endmodule

// File: tb/icache_parity_scan_bench.sv
`timescale 1ns/1ps
module icache_parity_scan_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [12:0] set_idx;
  logic        data_chk;
  logic        rd_en;
  logic        rd_data;
  logic [14:0] rd_addr;
  logic [31:0] rd_hi;
  logic [63:0] rd_lo;
  logic        done;
  logic [31:0] result;
  logic [1:0]  fail_way;

  always #2.5 clk = ~clk;

  icache_parity_scan u_icache_parity_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .set_idx(set_idx), .data_chk(data_chk),
    .rd_en(rd_en), .rd_data(rd_data), .rd_addr(rd_addr), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .done(done), .result(result), .fail_way(fail_way)
  );

  int total = 0;
  int bad   = 0;
  int lat   = 0;

  logic [31:0] m_thi [4];
  logic [63:0] m_tlo [4];
  logic [31:0] m_dhi [4][4];
  logic [63:0] m_dlo [4][4];

  logic [15:0] addr_q [$];
  logic [31:0] res_q  [$];
  logic [1:0]  way_q  [$];
  int          lat_q  [$];
  string       req_q  [$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Array model: one-cycle read latency.
  always @(posedge clk) begin
    if (rd_en) begin
      if (rd_data) begin
        rd_hi <= m_dhi[rd_addr[14:13]][rd_addr[4:3]];
        rd_lo <= m_dlo[rd_addr[14:13]][rd_addr[4:3]];
      end else begin
        rd_hi <= m_thi[rd_addr[14:13]];
        rd_lo <= m_tlo[rd_addr[14:13]];
      end
    end
  end

  function automatic logic ones_odd(logic [63:0] v, int hi, int lo);
    logic p = 1'b0;
    for (int i = lo; i <= hi; i++) p = p ^ v[i];
    return p;
  endfunction

  function automatic logic tag_low_par(logic [63:0] v);
    logic p = 1'b0;
    for (int i = 0; i < 24; i++) if (i != 10 && i != 11) p = p ^ v[i];
    return p;
  endfunction

  function automatic logic [3:0] inst_par(logic [31:0] w);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) r[3-j] = ones_odd({32'b0, w}, 31 - 8*j, 24 - 8*j);
    return r;
  endfunction

  task automatic load_clean(int seed);
    int s = $urandom(seed);
    for (int w = 0; w < 4; w++) begin
      m_thi[w] = $urandom;
      m_thi[w][29] = 1'b1;
      m_thi[w][27] = 1'b1;
      m_tlo[w] = {$urandom, $urandom};
      m_tlo[w][10] = tag_low_par(m_tlo[w]);
      m_tlo[w][11] = ones_odd(m_tlo[w], 63, 24);
      for (int b = 0; b < 4; b++) begin
        m_dhi[w][b] = $urandom;
        m_dlo[w][b] = {$urandom, $urandom};
        m_dhi[w][b][16]  = ones_odd({32'b0, m_dhi[w][b]}, 15, 8);
        m_dhi[w][b][7:4] = inst_par(m_dlo[w][b][63:32]);
        m_dhi[w][b][3:0] = inst_par(m_dlo[w][b][31:0]);
      end
    end
    s = s + 1;
  endtask

  task automatic expect_of(logic dchk, output logic [31:0] res, output logic [1:0] fw);
    logic tf = 1'b0, df = 1'b0, found = 1'b0;
    fw = 2'd0;
    for (int w = 0; w < 4; w++) begin
      logic werr = 1'b0;
      logic v = m_thi[w][29];
      if (m_thi[w][27] != v) begin tf = 1'b1; werr = 1'b1; end
      if (v && (m_tlo[w][10] != tag_low_par(m_tlo[w]) ||
                m_tlo[w][11] != ones_odd(m_tlo[w], 63, 24))) begin tf = 1'b1; werr = 1'b1; end
      if (dchk) begin
        for (int b = 0; b < 4; b++) begin
          if (m_dhi[w][b][16] != ones_odd({32'b0, m_dhi[w][b]}, 15, 8) ||
              m_dhi[w][b][7:4] != inst_par(m_dlo[w][b][63:32]) ||
              m_dhi[w][b][3:0] != inst_par(m_dlo[w][b][31:0])) begin df = 1'b1; werr = 1'b1; end
        end
      end
      if (werr && !found) begin found = 1'b1; fw = 2'(w); end
    end
    res = 32'(tf) << 29 | 32'(df) << 28;
  endtask

  // Driver: push expected reads and result, then pulse start.
  task automatic run_scan(logic [12:0] idx, logic dchk, string req, bit intrude);
    logic [31:0] er;
    logic [1:0]  ew;
    expect_of(dchk, er, ew);
    for (int w = 0; w < 4; w++) begin
      addr_q.push_back({1'b0, 2'(w), idx});
      if (dchk) for (int b = 0; b < 4; b++)
        addr_q.push_back({1'b1, 2'(w), idx | 13'(b << 3)});
    end
    res_q.push_back(er);
    way_q.push_back(ew);
    lat_q.push_back(dchk ? 22 : 6);
    req_q.push_back(req);
    @(negedge clk);
    start = 1'b1; set_idx = idx; data_chk = dchk;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    chk("R12 clear on start", {result, 30'b0, fail_way}, 64'd0);
    if (intrude) begin
      repeat (2) @(negedge clk);
      start = 1'b1; set_idx = ~idx & 13'h1FE0; data_chk = ~dchk;
      @(negedge clk);
      start = 1'b0;
    end
    wait (res_q.size() == 0);
    if (intrude) repeat (40) @(negedge clk);
    chk({req, " read count"}, 64'(addr_q.size()), 64'd0);
    addr_q.delete();
    @(negedge clk);
  endtask

  // Monitor: compare reads and results as they appear.
  always @(negedge clk) begin
    lat++;
    if (rst_n && rd_en) begin
      if (addr_q.size() == 0) chk("R1 unexpected read", {rd_data, rd_addr}, 64'hFFFF);
      else chk("R1 R2 read order", {rd_data, rd_addr}, addr_q.pop_front());
    end
    if (rst_n && done) begin
      if (res_q.size() == 0) chk("R11 unexpected done", 64'd1, 64'd0);
      else begin
        string r = req_q.pop_front();
        chk({r, " result"}, result, res_q.pop_front());
        chk({r, " R10 fail_way"}, fail_way, way_q.pop_front());
        chk("R13 latency", lat, lat_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held_r;
    logic [1:0]  held_w;
    rst_n = 1'b0; start = 1'b0; set_idx = '0; data_chk = 1'b0;
    rd_hi = '0; rd_lo = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset done", done, 0);
    chk("R13 reset rd_en", rd_en, 0);
    chk("R9 reset result", result, 0);
    chk("R10 reset fail_way", fail_way, 0);

    load_clean(1);  run_scan(13'h0A60, 1'b1, "R1", 0);
    load_clean(2);  run_scan(13'h1FE0, 1'b0, "R2", 0);
    load_clean(3);  m_tlo[2][10] ^= 1'b1; run_scan(13'h0120, 1'b1, "R3", 0);
    load_clean(4);  m_tlo[1][40] ^= 1'b1; run_scan(13'h0340, 1'b0, "R4", 0);
    load_clean(5);  m_thi[3][29] = 1'b0; m_thi[3][27] = 1'b0;
                    m_tlo[3][5] ^= 1'b1; m_tlo[3][50] ^= 1'b1;
                    run_scan(13'h1560, 1'b1, "R6", 0);
    load_clean(6);  m_thi[0][29] = 1'b0; m_thi[0][27] = 1'b1; run_scan(13'h0800, 1'b0, "R5", 0);
    load_clean(7);  m_thi[2][27] = 1'b0; run_scan(13'h00E0, 1'b1, "R5", 0);
    load_clean(8);  m_dhi[1][2][16] ^= 1'b1; run_scan(13'h1200, 1'b1, "R7", 0);
    load_clean(9);  m_dlo[3][3][62] ^= 1'b1; run_scan(13'h0FE0, 1'b1, "R8", 0);
    run_scan(13'h0FE0, 1'b0, "R9", 0);
    load_clean(10); m_dlo[0][1][63] ^= 1'b1; m_dhi[0][1][7] ^= 1'b1;
                    m_dlo[2][0][0]  ^= 1'b1; m_dhi[2][0][0] ^= 1'b1;
                    run_scan(13'h0460, 1'b1, "R8", 0);
    load_clean(11); m_dlo[0][0][63] ^= 1'b1; m_dhi[0][0][4] ^= 1'b1;
                    run_scan(13'h0AA0, 1'b1, "R8", 0);
    load_clean(12); m_dhi[1][3][0] ^= 1'b1; m_tlo[3][11] ^= 1'b1; m_tlo[2][3] ^= 1'b1;
                    run_scan(13'h1320, 1'b1, "R10", 0);
    held_r = result; held_w = fail_way;
    repeat (10) @(negedge clk);
    chk("R12 hold result", result, 32'h3000_0000);
    chk("R12 hold fail_way", fail_way, 2'd1);
    chk("R12 hold stable", {held_r, 30'b0, held_w}, {result, 30'b0, fail_way});
    load_clean(13); m_thi[0][27] ^= 1'b1; run_scan(13'h0660, 1'b1, "R11", 1);
    load_clean(14); run_scan(13'h01A0, 1'b1, "R12", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule